// File: doc/BRIEF.md
# Configurable Slice Storage Element Bank

This block models the storage stage of one logic slice: a bank of eight single-bit storage elements. Four are main elements and four are secondary elements. All eight share one set of slice-wide mode bits that are held static. The mode bits choose the following:

- edge-triggered flip-flop or level-sensitive latch operation
- synchronous or asynchronous set/reset
- polarity of the slice clock or gate
- whether the clock-enable input is honoured
- whether the set/reset input is honoured

Each element also has two bits of its own. One selects the value it takes on set/reset. The other selects the value it takes on a global-init pulse.

The block is an emulation that runs on a fast system clock `clk`. The slice clock or gate arrives on `slk` as an ordinary signal that is synchronous to `clk`. The block detects the active edge of `slk`, or its active level in latch mode, and updates the selected elements on the following `clk` edge. An element therefore responds one `clk` cycle after the stimulus that caused the change. In latch mode the secondary elements cannot be used and are held at 0. Setting latch mode together with synchronous reset is an illegal combination, and the block raises a flag when it sees it.

Top module: `slice_store_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released (release takes two `clk` cycles to reach the logic), every `q` bit is 0 and no slice edge is pending. A stable `slk` therefore causes no capture.
- R2: When `cfg_latch`=0, element i loads `d[i]` on the first `clk` edge after the active edge of `slk`. The active edge is the rising edge when `cfg_clkinv`=0 and the falling edge when `cfg_clkinv`=1. The opposite edge loads nothing.
- R3: When `cfg_ce_used`=0, the enable is treated as 1 and `ce` is ignored. When `cfg_ce_used`=1, a capture or a transparent update happens only while `ce`=1.
- R4: When `cfg_sr_used`=0, the `sr` input is ignored and data capture proceeds normally.
- R5: The set/reset value of element i is 0 when `cfg_rst_sel[i]`=1 and 1 when `cfg_rst_sel[i]`=0.
- R6: With `sr` active, the set/reset value is loaded as follows:
  - when `cfg_sync`=0, on the next `clk` edge whatever `slk` does;
  - when `cfg_sync`=1, only on a capture strobe.
- R7: A pulse on `init_pulse` loads each usable element with its init value on the next `clk` edge. The init value is the inverse of `cfg_init_sel[i]` in flip-flop mode and equal to `cfg_init_sel[i]` in latch mode. Global init wins over set/reset, and set/reset wins over data capture.
- R8: When `cfg_latch`=1, main element i follows `d[i]` (one `clk` cycle later) while the gate is active, and holds its value while the gate is inactive. The gate is active when `slk`=1 with `cfg_clkinv`=1, and when `slk`=0 with `cfg_clkinv`=0.
- R9: When `cfg_latch`=1, the secondary elements `q[7:4]` read 0 whatever happens on `d`, `init_pulse` or `sr`.
- R10: `cfg_err` is 1 exactly when `cfg_latch`=1 and `cfg_sync`=1.
- R11: An element with no capture strobe, no init pulse and no active set/reset keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all state updates |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slk | input | 1 | Slice clock (flip-flop mode) or gate (latch mode), synchronous to `clk` |
| ce | input | 1 | Clock or gate enable |
| sr | input | 1 | Set/reset request |
| init_pulse | input | 1 | Global-init request |
| d | input | 8 | Data inputs; bits 3:0 main, bits 7:4 secondary |
| cfg_latch | input | 1 | 1 selects latch mode |
| cfg_sync | input | 1 | 1 selects synchronous set/reset |
| cfg_clkinv | input | 1 | Slice clock or gate polarity bit |
| cfg_ce_used | input | 1 | 1 makes `ce` effective |
| cfg_sr_used | input | 1 | 1 makes `sr` effective |
| cfg_rst_sel | input | 8 | Per-element set/reset value select |
| cfg_init_sel | input | 8 | Per-element init value select |
| q | output | 8 | Element outputs |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
A wrong edge-history bit shows up at `q` as a spurious or missing capture on the first `clk` edge after an `slk` transition. A wrong element bit shows up at `q` at the next sample, because every element feeds its output pin directly. The checks place a changed `d` next to every `slk` transition, so a capture on the wrong polarity or a missed hold is visible within one cycle. They also use asymmetric bit patterns for data, set/reset value and init value, so that a swapped or inverted per-element select shows in specific bit positions. The two orderings of priority are each tested with both competing requests active in the same cycle.

// File: rtl/slice_store_pkg.sv
package slice_store_pkg;

  typedef struct packed {
    logic latch;
    logic sync;
    logic clkinv;
    logic ce_used;
    logic sr_used;
  } slice_mode_t;

  // set/reset value: select bit high gives 0, low gives 1
  function automatic logic sr_value(input logic sel);
    return ~sel;
  endfunction

  // init value: inverted sense in flip-flop mode, direct in latch mode
  function automatic logic init_value(input logic latch, input logic sel);
    return latch ? sel : ~sel;
  endfunction

endpackage

// File: rtl/slice_rst_sync.sv
module slice_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/slice_strobe_gen.sv
module slice_strobe_gen
  import slice_store_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slk,
  input  logic        ce,
  input  logic        sr,
  input  slice_mode_t mode,
  output logic        strobe,
  output logic        cen,
  output logic        rst_fire
);
  logic eff;
  logic eff_q;
  logic eff_q_nx;

  // effective clock/gate: polarity bit reverses meaning in latch mode
  assign eff = mode.latch ? (slk ^ ~mode.clkinv) : (slk ^ mode.clkinv);

  assign eff_q_nx = eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= 1'b1;
    else        eff_q <= eff_q_nx;
  end

  always_comb begin
    strobe   = mode.latch ? eff : (eff & ~eff_q);
    cen      = mode.ce_used ? ce : 1'b1;
    rst_fire = (mode.sr_used & sr) & (~mode.sync | strobe);
  end

  // R2: a flip-flop capture strobe lasts exactly one cycle
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.latch && strobe) |=> (mode.latch || !strobe));

endmodule

// File: rtl/slice_store_cell.sv
module slice_store_cell
  import slice_store_pkg::*;
#(
  parameter bit IS_SEC = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic strobe,
  input  logic cen,
  input  logic rst_fire,
  input  logic init_pulse,
  input  logic latch,
  input  logic rst_sel,
  input  logic init_sel,
  output logic q
);
  logic q_r;
  logic q_nx;
  logic off;
  logic rst_v;
  logic init_v;

  if (IS_SEC) begin : g_sec
    assign off = latch;
  end else begin : g_main
    assign off = 1'b0;
  end

  assign rst_v  = sr_value(rst_sel);
  assign init_v = init_value(latch, init_sel);

  always_comb begin
    q_nx = q_r;
    if (off)                 q_nx = 1'b0;
    else if (init_pulse)     q_nx = init_v;
    else if (rst_fire)       q_nx = rst_v;
    else if (strobe && cen)  q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_nx;
  end

  assign q = q_r;

  assert_init_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pulse && !off) |=> (q == $past(init_v)));

  assert_rst_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_fire && !init_pulse && !off) |=> (q == $past(rst_v)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && !init_pulse && !rst_fire && !(strobe && cen)) |=> $stable(q));

  assert_sec_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (q == 1'b0));

endmodule

// File: rtl/slice_store_bank.sv
module slice_store_bank
  import slice_store_pkg::*;
#(
  parameter int NMAIN = 4,
  parameter int NSEC  = 4,
  localparam int NUM  = NMAIN + NSEC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slk,
  input  logic           ce,
  input  logic           sr,
  input  logic           init_pulse,
  input  logic [NUM-1:0] d,
  input  logic           cfg_latch,
  input  logic           cfg_sync,
  input  logic           cfg_clkinv,
  input  logic           cfg_ce_used,
  input  logic           cfg_sr_used,
  input  logic [NUM-1:0] cfg_rst_sel,
  input  logic [NUM-1:0] cfg_init_sel,
  output logic [NUM-1:0] q,
  output logic           cfg_err
);
  slice_mode_t mode;
  logic        rst_n_sync;
  logic        strobe;
  logic        cen;
  logic        rst_fire;

  assign mode = '{latch: cfg_latch, sync: cfg_sync, clkinv: cfg_clkinv,
                  ce_used: cfg_ce_used, sr_used: cfg_sr_used};

  // R10: latch elements cannot take a synchronous set/reset
  assign cfg_err = cfg_latch & cfg_sync;

  slice_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  slice_strobe_gen i_strobe (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .slk      (slk),
    .ce       (ce),
    .sr       (sr),
    .mode     (mode),
    .strobe   (strobe),
    .cen      (cen),
    .rst_fire (rst_fire)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_elem
    slice_store_cell #(.IS_SEC(i >= NMAIN)) i_cell (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .d          (d[i]),
      .strobe     (strobe),
      .cen        (cen),
      .rst_fire   (rst_fire),
      .init_pulse (init_pulse),
      .latch      (cfg_latch),
      .rst_sel    (cfg_rst_sel[i]),
      .init_sel   (cfg_init_sel[i]),
      .q          (q[i])
    );
  end

  assert_sec_bank_off_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cfg_latch |=> (q[NUM-1:NMAIN] == '0));

endmodule

// File: tb/test_slice_store_bank.sv
module test_slice_store_bank;
  logic       clk = 1'b0;
  logic       rst_n, slk, ce, sr, init_pulse;
  logic [7:0] d, cfg_rst_sel, cfg_init_sel, q;
  logic       cfg_latch, cfg_sync, cfg_clkinv, cfg_ce_used, cfg_sr_used, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  slice_store_bank i_slice_store_bank (
    .clk(clk), .rst_n(rst_n), .slk(slk), .ce(ce), .sr(sr), .init_pulse(init_pulse),
    .d(d), .cfg_latch(cfg_latch), .cfg_sync(cfg_sync), .cfg_clkinv(cfg_clkinv),
    .cfg_ce_used(cfg_ce_used), .cfg_sr_used(cfg_sr_used), .cfg_rst_sel(cfg_rst_sel),
    .cfg_init_sel(cfg_init_sel), .q(q), .cfg_err(cfg_err)
  );

  // set/reset select 8'hCA -> values 8'h35; init select 8'h96 -> ff 8'h69, latch 8'h06
  localparam logic [7:0] RSEL = 8'hCA, RVAL = 8'h35;
  localparam logic [7:0] ISEL = 8'h96, IVAL_FF = 8'h69, IVAL_LAT = 8'h06;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_slk(input logic active);
    slk = active; step();
    slk = ~active; step();
  endtask

  task automatic setup(input logic lat, input logic syn, input logic inv, input logic slk0);
    rst_n = 1'b0;
    cfg_latch = lat; cfg_sync = syn; cfg_clkinv = inv;
    cfg_ce_used = 1'b0; cfg_sr_used = 1'b0;
    cfg_rst_sel = RSEL; cfg_init_sel = ISEL;
    slk = slk0; ce = 1'b0; sr = 1'b0; init_pulse = 1'b0; d = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_reset();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 q after reset", q, 8'h00);
    check("R10 legal config", {7'd0, cfg_err}, 8'h00);
  endtask

  task automatic t_ff_edge();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    d = 8'hA5; step();
    check("R11 no edge hold", q, 8'h00);
    slk = 1'b1; step();
    check("R2 rising capture", q, 8'hA5);
    d = 8'h3C; step();
    check("R11 slk high hold", q, 8'hA5);
    slk = 1'b0; step();
    check("R2 falling ignored", q, 8'hA5);
  endtask

  task automatic t_ff_inv();
    setup(1'b0, 1'b0, 1'b1, 1'b0);
    d = 8'h5A; slk = 1'b1; step();
    check("R2 inverted rising ignored", q, 8'h00);
    slk = 1'b0; step();
    check("R2 inverted falling capture", q, 8'h5A);
  endtask

  task automatic t_ce();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_ce_used = 1'b1; ce = 1'b0; d = 8'hFF;
    pulse_slk(1'b1);
    check("R3 ce low blocks", q, 8'h00);
    ce = 1'b1; pulse_slk(1'b1);
    check("R3 ce high captures", q, 8'hFF);
    cfg_ce_used = 1'b0; ce = 1'b0; d = 8'h0F;
    pulse_slk(1'b1);
    check("R3 ce unused ignores ce", q, 8'h0F);
  endtask

  task automatic t_sr_unused();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    sr = 1'b1; d = 8'h77; step();
    check("R4 sr ignored idle", q, 8'h00);
    pulse_slk(1'b1);
    check("R4 sr ignored capture", q, 8'h77);
    sr = 1'b0;
  endtask

  task automatic t_async();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_sr_used = 1'b1; d = 8'hC3;
    pulse_slk(1'b1);
    sr = 1'b1; step();
    check("R6 R5 async reset mid-cycle", q, RVAL);
    d = 8'hFF; pulse_slk(1'b1);
    check("R7 reset beats capture", q, RVAL);
    sr = 1'b0;
  endtask

  task automatic t_sync();
    setup(1'b0, 1'b1, 1'b0, 1'b0);
    cfg_sr_used = 1'b1; d = 8'hFF;
    pulse_slk(1'b1);
    sr = 1'b1; step(); step();
    check("R6 sync reset waits", q, 8'hFF);
    slk = 1'b1; step();
    check("R6 sync reset on edge", q, RVAL);
    slk = 1'b0; sr = 1'b0; step();
  endtask

  task automatic t_init_ff();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    cfg_sr_used = 1'b1; sr = 1'b1; init_pulse = 1'b1; step();
    check("R7 ff init beats reset", q, IVAL_FF);
    init_pulse = 1'b0; sr = 1'b0; step();
  endtask

  task automatic t_latch();
    setup(1'b1, 1'b0, 1'b1, 1'b0);
    check("R10 latch async legal", {7'd0, cfg_err}, 8'h00);
    d = 8'hFF; step();
    check("R8 latch opaque", q, 8'h00);
    slk = 1'b1; step();
    check("R8 R9 latch transparent", q, 8'h0F);
    d = 8'hF3; step();
    check("R8 latch follows", q, 8'h03);
    slk = 1'b0; d = 8'h0C; step();
    check("R8 latch holds", q, 8'h03);
    init_pulse = 1'b1; step(); init_pulse = 1'b0;
    check("R7 latch init", q, IVAL_LAT);
  endtask

  task automatic t_latch_inv();
    setup(1'b1, 1'b0, 1'b0, 1'b1);
    d = 8'hFA; step();
    check("R8 inverted gate opaque", q, 8'h00);
    slk = 1'b0; step();
    check("R8 R9 inverted gate transparent", q, 8'h0A);
  endtask

  task automatic t_illegal();
    setup(1'b1, 1'b1, 1'b1, 1'b0);
    check("R10 latch with sync flagged", {7'd0, cfg_err}, 8'h01);
    cfg_latch = 1'b0; #1;
    check("R10 ff with sync clear", {7'd0, cfg_err}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_ff_edge();
    t_ff_inv();
    t_ce();
    t_sr_unused();
    t_async();
    t_sync();
    t_init_ff();
    t_latch();
    t_latch_inv();
    t_illegal();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule